// File: doc/BRIEF.md
# Redundant Clock Selector Control and Status Registers

This block is the software-visible register file of a clock generator that picks its reference from four redundant inputs. It holds the divide ratio of each of the four output banks. It also holds the 3-bit mode that controls how the reference input is selected. It keeps one sticky failure flag for each clock input. The failure detector itself sits outside the block and reports each failed input as a one-cycle pulse on `fail_pulse`.

Software uses a plain synchronous port. The address and `wr_en` are sampled on the rising clock edge, and `rd_data` shows the addressed register combinationally. Two fields live in the mode register: the mode field and the per-input flag-clear bits. A single write therefore always sets the mode, even when its purpose is to clear flags. The clear bits never read back as 1. The divider fields and the mode also leave the block as plain control outputs, `div_sel` and `mode_sel`, which drive the rest of the generator. There is no handshake on any port.

Top module: `clkmon_csr`

## Requirements
- R1: While `rst_n` is low and after it is released, `div_sel`, `mode_sel` and `fail_flags` are all zero until a write or a fail pulse changes them.
- R2: A write to address 0 stores `wr_data` from the next cycle on `div_sel`. Bank A is in bits 7:6, bank B in 5:4, bank C in 3:2 and bank D in 1:0. The field codes are 00 = divide by 2, 01 = divide by 4, 10 = divide by 8 and 11 = divide by 16. Reading address 0 returns the stored byte.
- R3: A write to address 1 loads `wr_data[2:0]` into the mode from the next cycle. Reading address 1 returns the mode in effect in bits 2:0.
- R4: Reading address 1 returns zero in bits 7:3. The clear bits 6:3 read as zero, and bit 7 is unused.
- R5: A high `fail_pulse[i]` sets `fail_flags[i]` from the next cycle. The flag then stays set until it is cleared.
- R6: A write to address 1 with `wr_data[3+i]` = 1 clears `fail_flags[i]` from the next cycle. Several flags can be cleared in one write. A 0 in a clear bit leaves that flag as it was.
- R7: When a fail pulse and a clear hit the same flag in the same cycle, the flag is set in the next cycle.
- R8: Reading address 2 returns `fail_flags` in bits 3:0 and zero in bits 7:4. Reading address 3 returns zero.
- R9: A write to address 1 that clears flags also replaces the mode with `wr_data[2:0]`.
- R10: Writes to addresses 2 and 3 change no register, flag or output.
- R11: Suppose a flag is cleared while its input is still failed, and the detector pulses at least once every 4 cycles. The flag is then set again no later than 4 cycles after the clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address (0 divider, 1 mode/clear, 2 status, 3 reserved) |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| fail_pulse | input | 4 | Per-input failure pulse from the external detector |
| div_sel | output | 8 | Divider selections of banks A..D |
| mode_sel | output | 3 | Reference selection mode in effect |
| fail_flags | output | 4 | Sticky per-input failure flags |

## Verification
The assertions assume that `addr`, `wr_en`, `wr_data` and `fail_pulse` are known and stable at every rising edge. They do not assume any spacing of fail pulses. R11 holds only if the detector keeps pulsing a failed input at least once every 4 cycles, which is an assumption about the environment. The bench therefore checks R11 only in a directed case that meets that rule. The bench drives all inputs on the falling edge. The random phase keeps fail pulses sparse, so that clears have an observable effect.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  parameter int unsigned REG_DIV  = 0;
  parameter int unsigned REG_MODE = 1;
  parameter int unsigned REG_STAT = 2;
  // first clear bit inside the mode register; clear bits sit above the mode field
  parameter int unsigned CLR_LSB  = 3;
endpackage

// File: rtl/clkmon_divsel_reg.sv
module clkmon_divsel_reg #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned SEL_W     = 2,
  localparam int unsigned DIV_W    = NUM_BANKS * SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [DIV_W-1:0] wr_val,
  output logic [DIV_W-1:0] div_q
);
  // one field register per output bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [SEL_W-1:0] field_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      field_q <= '0;
      else if (wr_hit) field_q <= wr_val[b*SEL_W +: SEL_W];
    end
    assign div_q[b*SEL_W +: SEL_W] = field_q;
  end
endmodule

// File: rtl/clkmon_mode_reg.sv
module clkmon_mode_reg #(
  parameter int unsigned MODE_W = 3,
  parameter int unsigned NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [MODE_W-1:0] mode_val,
  input  logic [NUM_IN-1:0] clr_val,
  output logic [MODE_W-1:0] mode_q,
  output logic [NUM_IN-1:0] clr_mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= '0;
    else if (wr_hit) mode_q <= mode_val;
  end
  // clear bits are never stored: they act only in the cycle of the write
  assign clr_mask = wr_hit ? clr_val : '0;
endmodule

// File: rtl/clkmon_fail_flags.sv
module clkmon_fail_flags #(
  parameter int unsigned NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] set_pulse,
  input  logic [NUM_IN-1:0] clr_mask,
  output logic [NUM_IN-1:0] flags_q
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flags_q[i] <= 1'b0;
      else if (set_pulse[i]) flags_q[i] <= 1'b1;   // set wins over clear
      else if (clr_mask[i])  flags_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/clkmon_csr.sv
module clkmon_csr #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned NUM_IN    = 4,
  parameter int unsigned MODE_W    = 3,
  parameter int unsigned ADDR_W    = 2,
  localparam int unsigned DATA_W   = NUM_BANKS * SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_IN-1:0] fail_pulse,
  output logic [DATA_W-1:0] div_sel,
  output logic [MODE_W-1:0] mode_sel,
  output logic [NUM_IN-1:0] fail_flags
);
  import clkmon_pkg::*;

  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(REG_DIV);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(REG_MODE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

  logic              div_hit, mode_hit;
  logic [NUM_IN-1:0] clr_mask;

  assign div_hit  = wr_en && (addr == A_DIV);
  assign mode_hit = wr_en && (addr == A_MODE);

  clkmon_divsel_reg #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (div_hit),
    .wr_val (wr_data),
    .div_q  (div_sel)
  );

  clkmon_mode_reg #(.MODE_W(MODE_W), .NUM_IN(NUM_IN)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (mode_hit),
    .mode_val (wr_data[MODE_W-1:0]),
    .clr_val  (wr_data[CLR_LSB +: NUM_IN]),
    .mode_q   (mode_sel),
    .clr_mask (clr_mask)
  );

  clkmon_fail_flags #(.NUM_IN(NUM_IN)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (fail_pulse),
    .clr_mask  (clr_mask),
    .flags_q   (fail_flags)
  );

  always_comb begin
    unique case (addr)
      A_DIV:   rd_data = div_sel;
      A_MODE:  rd_data = {{(DATA_W-MODE_W){1'b0}}, mode_sel};
      A_STAT:  rd_data = {{(DATA_W-NUM_IN){1'b0}}, fail_flags};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/clkmon_csr_chk.sv
module clkmon_csr_chk #(
  parameter int unsigned NUM_IN = 4,
  parameter int unsigned MODE_W = 3,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [NUM_IN-1:0] fail_pulse,
  input logic [DATA_W-1:0] div_sel,
  input logic [MODE_W-1:0] mode_sel,
  input logic [NUM_IN-1:0] fail_flags
);
  import clkmon_pkg::*;

  logic              wr_div, wr_mode, wr_other;
  logic [NUM_IN-1:0] clr_req;

  assign wr_div   = wr_en && (addr == ADDR_W'(REG_DIV));
  assign wr_mode  = wr_en && (addr == ADDR_W'(REG_MODE));
  assign wr_other = wr_en && !wr_div && !wr_mode;
  assign clr_req  = wr_mode ? wr_data[CLR_LSB +: NUM_IN] : '0;

  // R2
  p_div_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> div_sel == $past(wr_data));

  // R3 and R9
  p_mode_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> mode_sel == $past(wr_data[MODE_W-1:0]));

  // R4
  p_mode_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(REG_MODE)) |-> rd_data[DATA_W-1:MODE_W] == '0);

  // R5
  p_pulse_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_pulse != '0) |=> (fail_flags & $past(fail_pulse)) == $past(fail_pulse));

  // R5: a flag only falls after a clear request
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(fail_flags) & ~fail_flags & ~$past(clr_req)) == '0);

  // R6
  p_clear_works_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req != '0) |=> (fail_flags & $past(clr_req) & ~$past(fail_pulse)) == '0);

  // R7
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_req & fail_pulse) != '0) |=> (fail_flags & $past(clr_req & fail_pulse)) != '0);

  // R10
  p_other_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_other && fail_pulse == '0) |=> $stable(div_sel) && $stable(mode_sel) && $stable(fail_flags));
endmodule

bind clkmon_csr clkmon_csr_chk #(
  .NUM_IN(NUM_IN), .MODE_W(MODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .fail_pulse(fail_pulse), .div_sel(div_sel),
  .mode_sel(mode_sel), .fail_flags(fail_flags)
);

// File: tb/clkmon_csr_test.sv
module clkmon_csr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] fail_pulse = '0;
  logic [7:0] div_sel;
  logic [2:0] mode_sel;
  logic [3:0] fail_flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m_div;
  logic [2:0] m_mode;
  logic [3:0] m_flags;

  always #10 clk = ~clk;   // 50 MHz

  clkmon_csr uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .fail_pulse(fail_pulse), .div_sel(div_sel),
    .mode_sel(mode_sel), .fail_flags(fail_flags)
  );

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_div;
      2'd1:    return {5'b0, m_mode};
      2'd2:    return {4'b0, m_flags};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    check(div_sel == m_div, {tag, " div_sel"}, div_sel, m_div);
    check(mode_sel == m_mode, {tag, " mode_sel"}, {5'b0, mode_sel}, {5'b0, m_mode});
    check(fail_flags == m_flags, {tag, " fail_flags"}, {4'b0, fail_flags}, {4'b0, m_flags});
  endtask

  // called at a falling edge: drive, check read, clock, update model, check outputs
  task automatic cycle(input logic [1:0] a, input bit w, input logic [7:0] d,
                       input logic [3:0] f, input string tag);
    addr = a; wr_en = w; wr_data = d; fail_pulse = f;
    #1;
    check(rd_data == exp_read(a), {tag, " rd_data"}, rd_data, exp_read(a));
    @(posedge clk);
    if (w && a == 2'd0) m_div = d;
    if (w && a == 2'd1) begin
      m_mode  = d[2:0];
      m_flags = m_flags & ~d[6:3];
    end
    m_flags = m_flags | f;
    @(negedge clk);
    check_outs(tag);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c10c));
    m_div = '0; m_mode = '0; m_flags = '0;
    repeat (3) @(negedge clk);
    check_outs("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1 after reset");
    cycle(2'd2, 1'b0, 8'h00, 4'h0, "R1 status read");

    // R2: each encoding in each bank
    cycle(2'd0, 1'b1, 8'b00_01_10_11, 4'h0, "R2 write");
    cycle(2'd0, 1'b0, 8'h00, 4'h0, "R2 readback");
    check(div_sel[7:6] == 2'b00 && div_sel[1:0] == 2'b11, "R2 bank A/D position", div_sel, 8'h1b);
    cycle(2'd0, 1'b1, 8'b11_10_01_00, 4'h0, "R2 write2");

    // R3, R4
    cycle(2'd1, 1'b1, 8'h85, 4'h0, "R3 mode write");
    cycle(2'd1, 1'b0, 8'h00, 4'h0, "R4 mode readback");
    check(rd_data[7:3] == 5'b0, "R4 upper bits", rd_data, {5'b0, m_mode});

    // R5: set and sticky
    cycle(2'd2, 1'b0, 8'h00, 4'b0101, "R5 pulse");
    cycle(2'd2, 1'b0, 8'h00, 4'h0, "R5 sticky");
    cycle(2'd2, 1'b0, 8'h00, 4'b1010, "R5 pulse2");

    // R6 multi clear plus R9 mode rewrite
    cycle(2'd1, 1'b1, 8'b0_0110_010, 4'h0, "R6 R9 clear two");
    check(fail_flags == 4'b1001, "R6 clear two", {4'b0, fail_flags}, 8'h09);
    check(mode_sel == 3'd2, "R9 mode rewritten", {5'b0, mode_sel}, 8'h02);
    cycle(2'd1, 1'b1, 8'b0_0000_011, 4'h0, "R6 zero no effect");

    // R7 set beats clear
    cycle(2'd1, 1'b1, 8'b0_0001_011, 4'b0001, "R7 set wins");
    check(fail_flags[0] == 1'b1, "R7 flag0", {4'b0, fail_flags}, 8'h09);

    // R8 / R10
    cycle(2'd3, 1'b0, 8'h00, 4'h0, "R8 reserved read");
    cycle(2'd2, 1'b1, 8'hff, 4'h0, "R10 write status");
    cycle(2'd3, 1'b1, 8'hff, 4'h0, "R10 write reserved");
    cycle(2'd2, 1'b0, 8'h00, 4'h0, "R8 status read");

    // R11: still-failed input pulsing every 4 cycles
    cycle(2'd1, 1'b1, 8'b0_1111_011, 4'h0, "R11 clear all");
    cycle(2'd2, 1'b0, 8'h00, 4'h0, "R11 gap1");
    cycle(2'd2, 1'b0, 8'h00, 4'h0, "R11 gap2");
    cycle(2'd2, 1'b0, 8'h00, 4'b0100, "R11 repulse");
    check(fail_flags[2] == 1'b1, "R11 reasserted", {4'b0, fail_flags}, 8'h04);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] ra;
      logic [3:0] rf;
      ra = 2'($urandom_range(0, 3));
      rf = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      cycle(ra, 1'($urandom), 8'($urandom), rf, "R2 R3 R5 R6 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule